// File: doc/BRIEF.md
# Swing-Sweeping Two-Phase Link Trainer

This controller brings up a multi-lane serial link between a transmitter end and a receiver end. One `start_i` pulse begins a run of numbered attempts. Each attempt first turns both ends off and clears the training pattern. It then turns both ends back on with the first training pattern (clock recovery), the latched lane-width code and a drive-level entry. The drive-level table holds four swing/emphasis settings: 400 mV at 0 dB, 400 mV at 6 dB, 600 mV at 3.5 dB and 800 mV at 0 dB. Each entry is used for two attempts in a row.

Within an attempt the block waits, then polls a sticky bit-lock flag a bounded number of times with fixed gaps between polls. When bit lock is seen, it switches both ends to the second training pattern (symbol alignment) and polls a sticky symbol-lock flag in the same way, with gaps three times longer. Whenever a flag is seen set, the block issues a one-cycle write-one-to-clear pulse for that flag. If every attempt is used up, the block reports failure. On success it selects the normal data pattern with enhanced framing, waits one idle-pattern time, turns on frame error correction and reports done.

All delays are counted in clock cycles, using a parameter that gives the number of cycles in half a microsecond.

Top module: `swing_link_trainer`

## Requirements
- R1: After synchronous reset: both enables are 0, `pattern_o` is 0, `done_o`, `fail_o`, `err_corr_o` and `enh_frame_o` are 0, and `lock_mask_o` is 2'b11 (both lock interrupts masked).
- R2: A `start_i` pulse is accepted only while idle. It clears `lock_mask_o` to 2'b00, sets the attempt number to 0 and latches `lane_cfg_i` onto `lane_width_o`. A `start_i` pulse during a run has no effect.
- R3: Every attempt starts with one state in which both enables are 0 and `pattern_o` is 0 (off). Both ends are then enabled together with `pattern_o` = 1 (pattern one).
- R4: In phase one, the block waits one half-microsecond unit and then samples `bit_lock_i`. It samples at most POLLS times, with one half-microsecond unit between samples.
- R5: When `bit_lock_i` is seen set, `clr_bit_o` pulses for exactly one cycle. In that same cycle `pattern_o` becomes 2 (pattern two).
- R6: In phase two, the wait before each of at most POLLS samples of `sym_lock_i` is three half-microsecond units. When the flag is seen set, `clr_sym_o` pulses for one cycle. The two clear pulses are never high together.
- R7: A phase that runs out of polls moves on to the next attempt. `swing_idx_o` equals the attempt number divided by TRIES (TRIES = 2), so the entry never decreases within a run.
- R8: When the last attempt (number LEVELS*TRIES-1 = 7) fails, `fail_o` rises, both ends are disabled, `pattern_o` returns to 0 and `attempt_o` stays at 7.
- R9: On symbol lock, `pattern_o` becomes 3 (normal) and `enh_frame_o` becomes 1. One half-microsecond unit later, `err_corr_o` and `done_o` rise together.
- R10: `done_o` and `fail_o` are never both high. Each one holds until the next accepted `start_i`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a training run (accepted only while idle) |
| lane_cfg_i | input | LANE_W | Lane-width code, latched at start |
| bit_lock_i | input | 1 | Sticky bit-lock flag from the receiver |
| sym_lock_i | input | 1 | Sticky symbol-lock flag from the receiver |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| pattern_o | output | 2 | 0 off, 1 pattern one, 2 pattern two, 3 normal |
| lane_width_o | output | LANE_W | Lane-width code driven to both ends |
| swing_idx_o | output | clog2(LEVELS) | Drive-level table entry in use |
| lock_mask_o | output | 2 | Interrupt masks {symbol, bit}; 1 = masked |
| clr_bit_o | output | 1 | Write-one pulse clearing the bit-lock flag |
| clr_sym_o | output | 1 | Write-one pulse clearing the symbol-lock flag |
| enh_frame_o | output | 1 | Enhanced framing enable |
| err_corr_o | output | 1 | Frame-start/frame-end error correction enable |
| done_o | output | 1 | Training succeeded |
| fail_o | output | 1 | All attempts failed |
| attempt_o | output | clog2(LEVELS*TRIES) | Current or final attempt number |

## Verification
The bench builds the trainer with a half-microsecond unit of 3 cycles and keeps the default four levels, two tries per level and four polls. This shortens each attempt to a few dozen cycles, so a run that uses all eight attempts, and runs that lock partway through the table, finish quickly. The lock flags are emulated as sticky bits that the clear pulses reset. Each flag can be held off until a chosen attempt and a chosen number of cycles into its phase, which exercises lock on a late poll, failure in phase two only, and a start pulse issued in the middle of a run.

// File: rtl/lt_pkg.sv
package lt_pkg;

  typedef enum logic [1:0] {
    PAT_OFF  = 2'd0,
    PAT_TP1  = 2'd1,
    PAT_TP2  = 2'd2,
    PAT_NORM = 2'd3
  } pat_e;

  typedef enum logic [3:0] {
    S_IDLE, S_DROP, S_ARM, S_W1, S_P1, S_W2, S_P2, S_NEXT, S_WI
  } st_e;

  // drive-level table entry used by a given attempt number
  function automatic int entry_of(input int attempt, input int tries);
    return attempt / tries;
  endfunction

  // wait length in cycles before a poll of the given phase
  function automatic int gap_cycles(input logic phase_two, input int half_cyc);
    return phase_two ? 3 * half_cyc : half_cyc;
  endfunction

endpackage

// File: rtl/lt_gap_timer.sv
module lt_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load_i)      cnt <= val_i;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired_o = (cnt == '0);

  // a wait of zero length would make the poll spacing vanish (R4)
  p_load_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    load_i |-> (val_i != '0));

endmodule

// File: rtl/lt_attempt_seq.sv
module lt_attempt_seq #(
  parameter int LEVELS = 4,
  parameter int TRIES  = 2,
  parameter int AW     = 3,
  parameter int EW     = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] attempt_o,
  output logic [EW-1:0] entry_o,
  output logic          last_o
);
  import lt_pkg::*;
  localparam int ATTEMPTS = LEVELS * TRIES;

  logic [AW-1:0] att;

  always_ff @(posedge clk) begin
    if (rst)         att <= '0;
    else if (clr_i)  att <= '0;
    else if (inc_i)  att <= att + 1'b1;
  end

  assign attempt_o = att;
  assign entry_o   = EW'(entry_of(int'(att), TRIES));
  assign last_o    = (int'(att) == ATTEMPTS - 1);

  p_attempt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    int'(attempt_o) <= ATTEMPTS - 1);

  p_no_inc_past_last_r8: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !clr_i) |-> !last_o);

endmodule

// File: rtl/swing_link_trainer.sv
module swing_link_trainer #(
  parameter int HALF_US_CYC = 63,
  parameter int LEVELS      = 4,
  parameter int TRIES       = 2,
  parameter int POLLS       = 4,
  parameter int LANE_W      = 2,
  localparam int ATTEMPTS   = LEVELS * TRIES,
  localparam int AW         = (ATTEMPTS > 1) ? $clog2(ATTEMPTS) : 1,
  localparam int EW         = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [LANE_W-1:0] lane_cfg_i,
  input  logic              bit_lock_i,
  input  logic              sym_lock_i,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic [1:0]        pattern_o,
  output logic [LANE_W-1:0] lane_width_o,
  output logic [EW-1:0]     swing_idx_o,
  output logic [1:0]        lock_mask_o,
  output logic              clr_bit_o,
  output logic              clr_sym_o,
  output logic              enh_frame_o,
  output logic              err_corr_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [AW-1:0]     attempt_o
);
  import lt_pkg::*;

  localparam int TW = $clog2(3 * HALF_US_CYC + 1);
  localparam int PW = (POLLS > 1) ? $clog2(POLLS) : 1;

  st_e           st;
  logic [PW-1:0] poll;
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic          att_clr, att_inc, att_last;
  logic [EW-1:0] entry;

  // named events
  logic accept_start, bit_hit, sym_hit, poll_last, busy;

  assign busy         = (st != S_IDLE);
  assign accept_start = (st == S_IDLE) && start_i;
  assign poll_last    = (int'(poll) == POLLS - 1);
  assign bit_hit      = (st == S_P1) && bit_lock_i;
  assign sym_hit      = (st == S_P2) && sym_lock_i;

  assign att_clr = accept_start;
  assign att_inc = (st == S_NEXT) && !att_last;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TW'(HALF_US_CYC);
    unique case (st)
      S_ARM: begin
        tmr_load = 1'b1;
        tmr_val  = TW'(gap_cycles(1'b0, HALF_US_CYC));
      end
      S_P1: begin
        tmr_load = bit_lock_i || !poll_last;
        tmr_val  = TW'(gap_cycles(bit_lock_i, HALF_US_CYC));
      end
      S_P2: begin
        tmr_load = sym_lock_i || !poll_last;
        tmr_val  = sym_lock_i ? TW'(HALF_US_CYC)
                              : TW'(gap_cycles(1'b1, HALF_US_CYC));
      end
      default: ;
    endcase
  end

  lt_gap_timer #(.W(TW)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (tmr_exp)
  );

  lt_attempt_seq #(.LEVELS(LEVELS), .TRIES(TRIES), .AW(AW), .EW(EW)) u_att (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (att_clr),
    .inc_i     (att_inc),
    .attempt_o (attempt_o),
    .entry_o   (entry),
    .last_o    (att_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      poll         <= '0;
      tx_en_o      <= 1'b0;
      rx_en_o      <= 1'b0;
      pattern_o    <= PAT_OFF;
      lane_width_o <= '0;
      swing_idx_o  <= '0;
      lock_mask_o  <= 2'b11;
      clr_bit_o    <= 1'b0;
      clr_sym_o    <= 1'b0;
      enh_frame_o  <= 1'b0;
      err_corr_o   <= 1'b0;
      done_o       <= 1'b0;
      fail_o       <= 1'b0;
    end else begin
      clr_bit_o <= 1'b0;
      clr_sym_o <= 1'b0;
      unique case (st)
        S_IDLE: if (start_i) begin
          lock_mask_o  <= 2'b00;
          done_o       <= 1'b0;
          fail_o       <= 1'b0;
          enh_frame_o  <= 1'b0;
          err_corr_o   <= 1'b0;
          swing_idx_o  <= '0;
          lane_width_o <= lane_cfg_i;
          st           <= S_DROP;
        end
        S_DROP: begin
          tx_en_o   <= 1'b0;
          rx_en_o   <= 1'b0;
          pattern_o <= PAT_OFF;
          st        <= S_ARM;
        end
        S_ARM: begin
          tx_en_o     <= 1'b1;
          rx_en_o     <= 1'b1;
          pattern_o   <= PAT_TP1;
          swing_idx_o <= entry;
          poll        <= '0;
          st          <= S_W1;
        end
        S_W1: if (tmr_exp) st <= S_P1;
        S_P1: begin
          if (bit_lock_i) begin
            clr_bit_o <= 1'b1;
            pattern_o <= PAT_TP2;
            poll      <= '0;
            st        <= S_W2;
          end else if (poll_last) begin
            st <= S_NEXT;
          end else begin
            poll <= poll + 1'b1;
            st   <= S_W1;
          end
        end
        S_W2: if (tmr_exp) st <= S_P2;
        S_P2: begin
          if (sym_lock_i) begin
            clr_sym_o   <= 1'b1;
            pattern_o   <= PAT_NORM;
            enh_frame_o <= 1'b1;
            st          <= S_WI;
          end else if (poll_last) begin
            st <= S_NEXT;
          end else begin
            poll <= poll + 1'b1;
            st   <= S_W2;
          end
        end
        S_NEXT: begin
          if (att_last) begin
            fail_o    <= 1'b1;
            tx_en_o   <= 1'b0;
            rx_en_o   <= 1'b0;
            pattern_o <= PAT_OFF;
            st        <= S_IDLE;
          end else begin
            st <= S_DROP;
          end
        end
        S_WI: if (tmr_exp) begin
          err_corr_o <= 1'b1;
          done_o     <= 1'b1;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_arm_from_off_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_ARM) |-> (!tx_en_o && !rx_en_o && pattern_o == PAT_OFF));

  p_bit_clear_tp2_r5: assert property (@(posedge clk) disable iff (rst)
    clr_bit_o |-> (pattern_o == PAT_TP2 && tx_en_o && rx_en_o));

  p_single_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clr_bit_o, clr_sym_o}));

  p_swing_monotonic_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (swing_idx_o >= $past(swing_idx_o)));

  p_fail_state_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_o) |-> (!tx_en_o && !rx_en_o && int'(attempt_o) == ATTEMPTS - 1));

  p_done_state_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> (err_corr_o && enh_frame_o && pattern_o == PAT_NORM));

  p_done_fail_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(done_o && fail_o));

  p_masks_open_busy_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (lock_mask_o == 2'b00));

endmodule

// File: tb/swing_link_trainer_tb_top.sv
module swing_link_trainer_tb_top;

  localparam int H      = 3;
  localparam int POLLS  = 4;
  localparam int TRIES  = 2;
  localparam int LEVELS = 4;
  localparam int NATT   = LEVELS * TRIES;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [1:0] lane_cfg_i = 2'd0;
  logic       bit_lock_i = 1'b0;
  logic       sym_lock_i = 1'b0;
  logic       tx_en_o, rx_en_o, clr_bit_o, clr_sym_o, enh_frame_o, err_corr_o;
  logic       done_o, fail_o;
  logic [1:0] pattern_o, lane_width_o, swing_idx_o, lock_mask_o;
  logic [2:0] attempt_o;

  always #4 clk = ~clk;

  swing_link_trainer #(.HALF_US_CYC(H), .LEVELS(LEVELS), .TRIES(TRIES),
                       .POLLS(POLLS), .LANE_W(2)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .lane_cfg_i(lane_cfg_i),
    .bit_lock_i(bit_lock_i), .sym_lock_i(sym_lock_i),
    .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .pattern_o(pattern_o),
    .lane_width_o(lane_width_o), .swing_idx_o(swing_idx_o),
    .lock_mask_o(lock_mask_o), .clr_bit_o(clr_bit_o), .clr_sym_o(clr_sym_o),
    .enh_frame_o(enh_frame_o), .err_corr_o(err_corr_o), .done_o(done_o),
    .fail_o(fail_o), .attempt_o(attempt_o)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- lock flag emulation (sticky, write-one-to-clear) -----
  int bl_att = 99, bl_dly = 0, sl_att = 99, sl_dly = 0;
  int tp1_cyc = 0, tp2_cyc = 0;

  always @(negedge clk) begin
    if (tx_en_o && pattern_o == 2'd1) tp1_cyc++; else tp1_cyc = 0;
    if (tx_en_o && pattern_o == 2'd2) tp2_cyc++; else tp2_cyc = 0;
    if (tp1_cyc > 0 && int'(attempt_o) >= bl_att && tp1_cyc > bl_dly) bit_lock_i = 1'b1;
    if (tp2_cyc > 0 && int'(attempt_o) >= sl_att && tp2_cyc > sl_dly) sym_lock_i = 1'b1;
  end

  always @(posedge clk) begin
    if (clr_bit_o) bit_lock_i <= 1'b0;
    if (clr_sym_o) sym_lock_i <= 1'b0;
  end

  // ---------------- behavioural reference model ---------------------------
  // phase: 0 idle, 1 both off, 2 re-enable, 3 wait-1, 4 sample-1,
  //        5 wait-2, 6 sample-2, 7 give up attempt, 8 idle-pattern wait
  int m_ph, m_left, m_poll, m_att;
  int m_tx, m_pat, m_width, m_sw, m_mask, m_cb, m_cs, m_enh, m_ecc, m_done, m_fail;
  bit m_valid = 0;

  always @(posedge clk) begin
    int left_before;
    if (rst) begin
      m_ph = 0; m_left = 0; m_poll = 0; m_att = 0;
      m_tx = 0; m_pat = 0; m_width = 0; m_sw = 0; m_mask = 3;
      m_cb = 0; m_cs = 0; m_enh = 0; m_ecc = 0; m_done = 0; m_fail = 0;
      m_valid = 1;
    end else begin
      left_before = m_left;
      if (m_left > 0) m_left--;
      m_cb = 0; m_cs = 0;
      case (m_ph)
        0: if (start_i) begin
             m_mask = 0; m_done = 0; m_fail = 0; m_enh = 0; m_ecc = 0;
             m_sw = 0; m_width = lane_cfg_i; m_att = 0; m_ph = 1;
           end
        1: begin m_tx = 0; m_pat = 0; m_ph = 2; end
        2: begin
             m_tx = 1; m_pat = 1; m_sw = m_att / TRIES; m_poll = 0;
             m_left = H; m_ph = 3;
           end
        3: if (left_before == 0) m_ph = 4;
        4: if (bit_lock_i) begin
             m_cb = 1; m_pat = 2; m_poll = 0; m_left = 3 * H; m_ph = 5;
           end else if (m_poll == POLLS - 1) m_ph = 7;
           else begin m_poll++; m_left = H; m_ph = 3; end
        5: if (left_before == 0) m_ph = 6;
        6: if (sym_lock_i) begin
             m_cs = 1; m_pat = 3; m_enh = 1; m_left = H; m_ph = 8;
           end else if (m_poll == POLLS - 1) m_ph = 7;
           else begin m_poll++; m_left = 3 * H; m_ph = 5; end
        7: if (m_att == NATT - 1) begin
             m_fail = 1; m_tx = 0; m_pat = 0; m_ph = 0;
           end else begin m_att++; m_ph = 1; end
        8: if (left_before == 0) begin m_ecc = 1; m_done = 1; m_ph = 0; end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (m_valid) begin
      check("R3 tx_en", int'(tx_en_o), m_tx);
      check("R3 rx_en", int'(rx_en_o), m_tx);
      check("R3 pattern", int'(pattern_o), m_pat);
      check("R2 lane_width", int'(lane_width_o), m_width);
      check("R7 swing_idx", int'(swing_idx_o), m_sw);
      check("R2 lock_mask", int'(lock_mask_o), m_mask);
      check("R5 clr_bit", int'(clr_bit_o), m_cb);
      check("R6 clr_sym", int'(clr_sym_o), m_cs);
      check("R9 enh_frame", int'(enh_frame_o), m_enh);
      check("R9 err_corr", int'(err_corr_o), m_ecc);
      check("R9 done", int'(done_o), m_done);
      check("R8 fail", int'(fail_o), m_fail);
      check("R7 attempt", int'(attempt_o), m_att);
    end
  end

  // ---------------- stimulus ----------------------------------------------
  task automatic pulse_start(input logic [1:0] lanes);
    @(negedge clk);
    lane_cfg_i = lanes;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic setup_locks(input int ba, input int bd, input int sa, input int sd);
    @(negedge clk);
    bl_att = ba; bl_dly = bd; sl_att = sa; sl_dly = sd;
    bit_lock_i = 1'b0; sym_lock_i = 1'b0;
  endtask

  task automatic wait_end(input string tag);
    int n = 0;
    while (!(done_o || fail_o) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) check({tag, " watchdog"}, 0, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check("R1 global watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 reset tx_en", int'(tx_en_o), 0);
    check("R1 reset pattern", int'(pattern_o), 0);
    check("R1 reset mask", int'(lock_mask_o), 3);
    check("R1 reset done", int'(done_o), 0);

    // A: immediate locks, first attempt succeeds (R4, R5, R6, R9)
    setup_locks(0, 0, 0, 0);
    pulse_start(2'd3);
    check("R2 mask cleared after start", int'(lock_mask_o), 0);
    wait_end("R9 run A");
    @(negedge clk);
    check("R9 run A done", int'(done_o), 1);
    check("R9 run A attempt", int'(attempt_o), 0);
    check("R9 run A pattern normal", int'(pattern_o), 3);
    check("R2 run A lane width", int'(lane_width_o), 3);

    // B: bit lock only from attempt 3, late in its phase (R4, R7)
    setup_locks(3, 7, 0, 0);
    pulse_start(2'd1);
    check("R10 done cleared by start", int'(done_o), 0);
    wait_end("R7 run B");
    @(negedge clk);
    check("R7 run B attempt", int'(attempt_o), 3);
    check("R7 run B swing", int'(swing_idx_o), 1);

    // C: phase two fails until attempt 5; start mid-run ignored (R2, R6)
    setup_locks(0, 0, 5, 10);
    pulse_start(2'd2);
    repeat (40) @(negedge clk);
    start_i = 1'b1;
    lane_cfg_i = 2'd0;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy start ignored width", int'(lane_width_o), 2);
    wait_end("R6 run C");
    @(negedge clk);
    check("R6 run C attempt", int'(attempt_o), 5);
    check("R7 run C swing", int'(swing_idx_o), 2);

    // D: never locks, all attempts used (R8, R10)
    setup_locks(99, 0, 99, 0);
    pulse_start(2'd0);
    wait_end("R8 run D");
    @(negedge clk);
    check("R8 run D fail", int'(fail_o), 1);
    check("R8 run D attempt", int'(attempt_o), NATT - 1);
    check("R8 run D ends off", int'(tx_en_o), 0);
    check("R10 run D not done", int'(done_o), 0);
    repeat (5) @(negedge clk);
    check("R10 fail held", int'(fail_o), 1);

    // E: success after failure clears fail (R10)
    setup_locks(0, 2, 0, 4);
    pulse_start(2'd1);
    check("R10 fail cleared by start", int'(fail_o), 0);
    wait_end("R9 run E");
    @(negedge clk);
    check("R9 run E done", int'(done_o), 1);
    check("R9 run E err_corr", int'(err_corr_o), 1);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule